// File: doc/BRIEF.md
# MCTP SMBus Block-Write Packet Framer

This block turns one MCTP packet held in a local byte buffer into the byte sequence of an SMBus Block-Write transaction. It hands that sequence to a downstream byte-level I2C/SMBus master engine. A request pulse supplies four things: the 7-bit address of the receiving endpoint, the 7-bit local address, the 32-bit MCTP transport header, and the payload length. The framer then reads the payload bytes one at a time through a small index/data port into the buffer. It prefixes the SMBus header fields and appends a packet error check (PEC) byte.

The output is a valid/ready byte stream. The first byte of each frame is flagged with a start marker and the PEC byte with an end marker. Only write transactions are produced. Bus arbitration, line signalling, clock stretching and splitting messages into packets are handled elsewhere.

A request is taken only while the framer is idle. A request with a length outside the range the block supports produces a one-cycle error pulse and no output.

Top module: `mctp_smb_framer`

## Requirements
- R1: The first byte of a frame carries the start marker and equals the destination address shifted left by one with bit 0 cleared (write).
- R2: The second byte is the fixed command code 0x0F.
- R3: The third byte is the byte count, equal to payload length + 5 (one source byte, four header bytes and the payload; the PEC is not counted).
- R4: The fourth byte is the source address shifted left by one with bit 0 set to 1.
- R5: Bytes 5 to 8 are the transport header, most significant byte first. They are followed by the payload bytes in buffer order, index 0 to length-1, each read at the index shown on `buf_idx` during that byte.
- R6: The final byte is the PEC. It is a CRC-8 with polynomial 0x07 (x^8+x^2+x+1), initial value 0 and most significant bit first, taken over every earlier byte of the frame. It carries the end marker, so a frame is length + 9 bytes long. After it is accepted, `tx_valid` and `busy` are low on the next cycle.
- R7: While `tx_valid` is high and `tx_ready` is low, the byte and both markers hold their values into the next cycle.
- R8: A request while idle with length 0 or length above 64 raises `err` for exactly the next cycle. No byte is offered.
- R9: A request made while a frame is in progress is ignored. The frame in progress continues unchanged and `err` stays low.
- R10: During and right after reset, `tx_valid`, `busy` and `err` are low.
- R11: The start marker is set only on the first byte and the end marker only on the last. Neither marker is set while `tx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_go | input | 1 | One-cycle request to frame a packet |
| req_dst | input | 7 | Destination endpoint address |
| req_src | input | 7 | Local source address |
| req_hdr | input | 32 | MCTP transport header, byte 0 in bits 31:24 |
| req_len | input | 7 | Payload length in bytes |
| busy | output | 1 | A frame is in progress |
| err | output | 1 | One-cycle pulse for a rejected length |
| buf_idx | output | 6 | Payload buffer read index |
| buf_byte | input | 8 | Payload byte at `buf_idx` (combinational read) |
| tx_data | output | 8 | Output byte |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_sof | output | 1 | First byte of frame |
| tx_eof | output | 1 | Last byte (PEC) of frame |

## Verification
The assertions assume that `buf_byte` is a combinational function of `buf_idx` and that it stays stable while a byte is stalled. They also assume that `tx_ready` may change freely, with no dependence on `tx_valid`. The stimulus meets these assumptions by modelling the buffer as a pure function of a per-frame seed and the index, and by keeping that seed fixed until the frame's end marker has been accepted. It toggles `tx_ready` in fixed patterns (always, every other cycle, one in three). Every payload length it offers is either in the accepted range or one of the rejected boundary values.

// File: rtl/mctp_smb_pkg.sv
package mctp_smb_pkg;

  localparam logic [7:0] SMB_CMD_MCTP = 8'h0F;
  localparam int unsigned SMB_PRE_BYTES = 4;
  localparam int unsigned MCTP_HDR_BYTES = 4;

  typedef enum logic [2:0] {
    SEG_DST,
    SEG_CMD,
    SEG_CNT,
    SEG_SRC,
    SEG_HDR,
    SEG_PAY,
    SEG_PEC
  } seg_t;

  // One CRC-8 update, polynomial 0x07, MSB first.
  function automatic logic [7:0] pec_update(input logic [7:0] crc, input logic [7:0] din);
    logic [7:0] c;
    c = crc ^ din;
    for (int b = 0; b < 8; b++) begin
      c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

  // Block-Write count: source byte, transport header and payload.
  function automatic logic [7:0] block_count(input logic [7:0] paylen);
    return paylen + 8'(1 + MCTP_HDR_BYTES);
  endfunction

  function automatic logic [7:0] addr_byte(input logic [6:0] a, input logic rd);
    return {a, rd};
  endfunction

endpackage

// File: rtl/smb_pec_acc.sv
module smb_pec_acc
  import mctp_smb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] crc
);

  logic [7:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      crc_q <= 8'h00;
    end else if (en) begin
      crc_q <= pec_update(crc_q, din);
    end
  end

  assign crc = crc_q;

endmodule

// File: rtl/smb_frame_seq.sv
module smb_frame_seq
  import mctp_smb_pkg::*;
#(
  parameter int unsigned MAX_PAY = 64,
  localparam int unsigned LEN_W = $clog2(MAX_PAY + 1),
  localparam int unsigned IDX_W = $clog2(MAX_PAY),
  localparam int unsigned POS_W = $clog2(MAX_PAY + SMB_PRE_BYTES + MCTP_HDR_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic             step,
  output logic             busy,
  output seg_t             seg,
  output logic [1:0]       hdr_sel,
  output logic [IDX_W-1:0] pay_idx,
  output logic             last,
  output logic [7:0]       count_byte
);

  localparam logic [POS_W-1:0] PAY_BASE = POS_W'(SMB_PRE_BYTES + MCTP_HDR_BYTES);

  logic [POS_W-1:0] pos_q;
  logic [LEN_W-1:0] len_q;
  logic             busy_q;
  logic [POS_W-1:0] pec_pos;

  assign pec_pos = POS_W'(len_q) + PAY_BASE;
  assign last    = (pos_q == pec_pos);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
      len_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      pos_q  <= '0;
      len_q  <= len;
    end else if (busy_q && step) begin
      if (last) begin
        busy_q <= 1'b0;
      end else begin
        pos_q <= pos_q + POS_W'(1);
      end
    end
  end

  always_comb begin
    if (pos_q == POS_W'(0))           seg = SEG_DST;
    else if (pos_q == POS_W'(1))      seg = SEG_CMD;
    else if (pos_q == POS_W'(2))      seg = SEG_CNT;
    else if (pos_q == POS_W'(3))      seg = SEG_SRC;
    else if (pos_q < PAY_BASE)        seg = SEG_HDR;
    else if (pos_q < pec_pos)         seg = SEG_PAY;
    else                              seg = SEG_PEC;
  end

  assign busy       = busy_q;
  assign hdr_sel    = pos_q[1:0];
  assign pay_idx    = IDX_W'(pos_q - PAY_BASE);
  assign count_byte = block_count(8'(len_q));

endmodule

// File: rtl/smb_byte_mux.sv
module smb_byte_mux
  import mctp_smb_pkg::*;
(
  input  seg_t        seg,
  input  logic [6:0]  dst,
  input  logic [6:0]  src,
  input  logic [31:0] hdr,
  input  logic [1:0]  hdr_sel,
  input  logic [7:0]  count_byte,
  input  logic [7:0]  pay,
  input  logic [7:0]  pec,
  output logic [7:0]  byte_o
);

  logic [7:0] hdr_bytes [MCTP_HDR_BYTES];

  for (genvar k = 0; k < MCTP_HDR_BYTES; k++) begin : g_hdr
    assign hdr_bytes[k] = hdr[31 - 8*k -: 8];
  end

  always_comb begin
    unique case (seg)
      SEG_DST: byte_o = addr_byte(dst, 1'b0);
      SEG_CMD: byte_o = SMB_CMD_MCTP;
      SEG_CNT: byte_o = count_byte;
      SEG_SRC: byte_o = addr_byte(src, 1'b1);
      SEG_HDR: byte_o = hdr_bytes[hdr_sel];
      SEG_PAY: byte_o = pay;
      default: byte_o = pec;
    endcase
  end

endmodule

// File: rtl/mctp_smb_framer.sv
module mctp_smb_framer
  import mctp_smb_pkg::*;
#(
  parameter int unsigned MAX_PAY = 64,
  localparam int unsigned LEN_W = $clog2(MAX_PAY + 1),
  localparam int unsigned IDX_W = $clog2(MAX_PAY)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_go,
  input  logic [6:0]       req_dst,
  input  logic [6:0]       req_src,
  input  logic [31:0]      req_hdr,
  input  logic [LEN_W-1:0] req_len,
  output logic             busy,
  output logic             err,
  output logic [IDX_W-1:0] buf_idx,
  input  logic [7:0]       buf_byte,
  output logic [7:0]       tx_data,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic             tx_sof,
  output logic             tx_eof
);

  logic        len_bad;
  logic        frame_accept;
  logic        frame_reject;
  logic        tx_fire;
  logic        frame_last;
  logic        busy_w;
  logic        err_q;
  logic [6:0]  dst_q;
  logic [6:0]  src_q;
  logic [31:0] hdr_q;
  seg_t        seg;
  logic [1:0]  hdr_sel;
  logic [7:0]  count_byte;
  logic [7:0]  pec_byte;

  assign len_bad      = (req_len == '0) || (req_len > LEN_W'(MAX_PAY));
  assign frame_accept = req_go && !busy_w && !len_bad;
  assign frame_reject = req_go && !busy_w && len_bad;
  assign tx_fire      = tx_valid && tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      dst_q <= '0;
      src_q <= '0;
      hdr_q <= '0;
    end else begin
      err_q <= frame_reject;
      if (frame_accept) begin
        dst_q <= req_dst;
        src_q <= req_src;
        hdr_q <= req_hdr;
      end
    end
  end

  smb_frame_seq #(.MAX_PAY(MAX_PAY)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (frame_accept),
    .len        (req_len),
    .step       (tx_fire),
    .busy       (busy_w),
    .seg        (seg),
    .hdr_sel    (hdr_sel),
    .pay_idx    (buf_idx),
    .last       (frame_last),
    .count_byte (count_byte)
  );

  smb_pec_acc u_pec (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (frame_accept),
    .en    (tx_fire && !frame_last),
    .din   (tx_data),
    .crc   (pec_byte)
  );

  smb_byte_mux u_mux (
    .seg        (seg),
    .dst        (dst_q),
    .src        (src_q),
    .hdr        (hdr_q),
    .hdr_sel    (hdr_sel),
    .count_byte (count_byte),
    .pay        (buf_byte),
    .pec        (pec_byte),
    .byte_o     (tx_data)
  );

  assign busy     = busy_w;
  assign err      = err_q;
  assign tx_valid = busy_w;
  assign tx_sof   = busy_w && (seg == SEG_DST);
  assign tx_eof   = busy_w && frame_last;

endmodule

// File: rtl/mctp_smb_framer_chk.sv
module mctp_smb_framer_chk #(
  parameter int unsigned MAX_PAY = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_go,
  input logic       busy,
  input logic       err,
  input logic [7:0] tx_data,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       tx_sof,
  input logic       tx_eof,
  input logic       fire
);

  localparam int unsigned NW = $clog2(MAX_PAY + 10);

  logic [NW-1:0] n_q;
  logic [7:0]    cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_q   <= '0;
      cnt_q <= '0;
    end else if (fire) begin
      n_q <= tx_eof ? '0 : n_q + NW'(1);
      if (n_q == NW'(2)) cnt_q <= tx_data;
    end
  end

  a_r1_dest_write: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_sof |-> !tx_data[0]);

  a_r2_cmd_second: assert property (@(posedge clk) disable iff (!rst_n)
    fire && tx_sof |=> tx_valid && tx_data == 8'h0F);

  a_r3_count_spans_frame: assert property (@(posedge clk) disable iff (!rst_n)
    fire && tx_eof |-> 32'(n_q) == 32'(cnt_q) + 32'd3);

  a_r4_src_read_bit: assert property (@(posedge clk) disable iff (!rst_n)
    fire && n_q == NW'(3) |-> tx_data[0]);

  a_r6_idle_after_pec: assert property (@(posedge clk) disable iff (!rst_n)
    fire && tx_eof |=> !tx_valid && !busy);

  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_eof));

  a_r8_err_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !tx_valid);

  a_r9_busy_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    busy && req_go |=> !err);

  a_r11_markers_apart: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !(tx_sof && tx_eof));

  a_r11_markers_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid |-> !tx_sof && !tx_eof);

endmodule

bind mctp_smb_framer mctp_smb_framer_chk #(.MAX_PAY(MAX_PAY)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_go   (req_go),
  .busy     (busy),
  .err      (err),
  .tx_data  (tx_data),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_sof   (tx_sof),
  .tx_eof   (tx_eof),
  .fire     (tx_fire)
);

// File: tb/test_mctp_smb_framer.sv
module test_mctp_smb_framer;

  logic        clk;
  logic        rst_n;
  logic        req_go;
  logic [6:0]  req_dst;
  logic [6:0]  req_src;
  logic [31:0] req_hdr;
  logic [6:0]  req_len;
  logic        busy;
  logic        err;
  logic [5:0]  buf_idx;
  logic [7:0]  buf_byte;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready;
  logic        tx_sof;
  logic        tx_eof;

  int unsigned n_tests;
  int unsigned n_fail;
  logic [7:0]  cur_seed;
  logic [7:0]  exp_b [80];

  // {dst, src, hdr, len, seed, ready mode}; mode 0 always, 1 every other, 2 one in three
  localparam int NV = 5;
  localparam logic [62:0] VEC [NV] = '{
    {7'h10, 7'h08, 32'h010A0BC8, 7'd1,  8'h00, 2'd0},
    {7'h2C, 7'h51, 32'h012008D3, 7'd64, 8'h5A, 2'd0},
    {7'h7F, 7'h00, 32'hFFFFFFFF, 7'd17, 8'hF0, 2'd1},
    {7'h00, 7'h7F, 32'h00000000, 7'd64, 8'h33, 2'd2},
    {7'h1D, 7'h62, 32'h010509A1, 7'd63, 8'h81, 2'd1}
  };

  function automatic logic [7:0] pay_byte(input logic [7:0] s, input logic [5:0] i);
    return s + 8'(i) * 8'd7;
  endfunction

  assign buf_byte = pay_byte(cur_seed, buf_idx);

  mctp_smb_framer i_mctp_smb_framer (
    .clk(clk), .rst_n(rst_n), .req_go(req_go), .req_dst(req_dst), .req_src(req_src),
    .req_hdr(req_hdr), .req_len(req_len), .busy(busy), .err(err), .buf_idx(buf_idx),
    .buf_byte(buf_byte), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_sof(tx_sof), .tx_eof(tx_eof)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string pos_tag(input int n, input int len);
    if (n == 0) return "R1 dest byte";
    if (n == 1) return "R2 command";
    if (n == 2) return "R3 byte count";
    if (n == 3) return "R4 source byte";
    if (n < len + 8) return "R5 header/payload";
    return "R6 pec";
  endfunction

  // Expected frame: serial bit-at-a-time CRC, written independently.
  task automatic build_exp(input logic [6:0] d, input logic [6:0] s, input logic [31:0] h,
                           input int len, input logic [7:0] seed);
    logic [7:0] c;
    logic fb;
    exp_b[0] = {d, 1'b0};
    exp_b[1] = 8'h0F;
    exp_b[2] = 8'(len + 5);
    exp_b[3] = {s, 1'b1};
    exp_b[4] = h[31:24];
    exp_b[5] = h[23:16];
    exp_b[6] = h[15:8];
    exp_b[7] = h[7:0];
    for (int i = 0; i < len; i++) exp_b[8 + i] = pay_byte(seed, 6'(i));
    c = 8'h00;
    for (int i = 0; i < len + 8; i++) begin
      for (int b = 7; b >= 0; b--) begin
        fb = c[7] ^ exp_b[i][b];
        c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
      end
    end
    exp_b[len + 8] = c;
  endtask

  // inject: 0 none, 1 valid request while busy, 2 zero-length request while busy
  task automatic run_frame(input logic [6:0] d, input logic [6:0] s, input logic [31:0] h,
                           input int len, input logic [7:0] seed, input int mode, input int inject);
    int n;
    int guard;
    bit done;
    bit stall_prev;
    bit err_seen;
    logic [7:0] prev_data;
    logic prev_sof;
    logic prev_eof;
    bit rdy;
    string itag;
    build_exp(d, s, h, len, seed);
    itag = (inject != 0) ? "R9 frame unchanged" : "";
    @(negedge clk);
    cur_seed = seed;
    req_dst = d; req_src = s; req_hdr = h; req_len = 7'(len); req_go = 1'b1;
    tx_ready = 1'b0;
    @(negedge clk);
    req_go = 1'b0;
    n = 0; guard = 0; done = 1'b0; stall_prev = 1'b0; err_seen = 1'b0;
    prev_data = '0; prev_sof = 1'b0; prev_eof = 1'b0;
    while (!done && guard < 2000) begin
      if (inject != 0 && guard == 0) begin
        req_go = 1'b1;
        req_dst = ~d; req_src = ~s; req_hdr = ~h;
        req_len = (inject == 1) ? 7'd5 : 7'd0;
      end else begin
        req_go = 1'b0;
      end
      case (mode)
        0: rdy = 1'b1;
        1: rdy = (guard % 2) == 1;
        default: rdy = (guard % 3) == 2;
      endcase
      tx_ready = rdy;
      #1;
      if (err) err_seen = 1'b1;
      if (stall_prev) begin
        chk(tx_valid && tx_data == prev_data && tx_sof == prev_sof && tx_eof == prev_eof,
            "R7 stalled byte held", {tx_valid, tx_sof, tx_eof, tx_data}, {1'b1, prev_sof, prev_eof, prev_data});
      end
      if (tx_valid && tx_ready) begin
        chk(tx_data == exp_b[n], {pos_tag(n, len), " ", itag}, tx_data, exp_b[n]);
        chk(tx_sof == (n == 0) && tx_eof == (n == len + 8), "R11 markers",
            {tx_sof, tx_eof}, {n == 0, n == len + 8});
        if (tx_eof) done = 1'b1;
        n++;
      end
      stall_prev = tx_valid && !tx_ready;
      prev_data = tx_data; prev_sof = tx_sof; prev_eof = tx_eof;
      @(negedge clk);
      guard++;
    end
    req_go = 1'b0;
    tx_ready = 1'b0;
    #1;
    chk(n == len + 9, "R6 frame length", n, len + 9);
    chk(!tx_valid && !busy, "R6 idle after pec", {tx_valid, busy}, 0);
    chk(!err_seen, (inject != 0) ? "R9 no err while busy" : "R8 no err on good length", err_seen, 0);
  endtask

  task automatic bad_len(input logic [6:0] l);
    @(negedge clk);
    req_len = l; req_go = 1'b1; tx_ready = 1'b1;
    @(negedge clk);
    req_go = 1'b0;
    #1;
    chk(err == 1'b1, "R8 err pulse", err, 1);
    chk(!tx_valid && !busy, "R8 no frame", {tx_valid, busy}, 0);
    @(negedge clk);
    #1;
    chk(err == 1'b0, "R8 err one cycle", err, 0);
    chk(!tx_valid && !busy, "R8 still idle", {tx_valid, busy}, 0);
    tx_ready = 1'b0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #1500000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    n_tests = 0; n_fail = 0;
    rst_n = 1'b0; req_go = 1'b0; req_dst = '0; req_src = '0; req_hdr = '0; req_len = '0;
    tx_ready = 1'b0; cur_seed = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(!tx_valid && !busy && !err, "R10 reset state", {tx_valid, busy, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!tx_valid && !busy && !err && !tx_sof && !tx_eof, "R10 after reset",
        {tx_valid, busy, err, tx_sof, tx_eof}, 0);

    for (int v = 0; v < NV; v++) begin
      run_frame(VEC[v][62:56], VEC[v][55:49], VEC[v][48:17], int'(VEC[v][16:10]),
                VEC[v][9:2], int'(VEC[v][1:0]), 0);
    end

    bad_len(7'd0);
    bad_len(7'd65);
    bad_len(7'd127);

    run_frame(7'h3A, 7'h21, 32'h01C0FFEE, 9, 8'h44, 2, 1);
    run_frame(7'h55, 7'h2A, 32'h0102A5C3, 2, 8'h10, 1, 2);
    run_frame(7'h40, 7'h41, 32'h01000001, 64, 8'hFE, 1, 0);

    finish_run();
  end

endmodule